// File: doc/BRIEF.md
# Selectable-Frequency Stepped PWM Generator

This block turns a 4 MHz reference clock into a switching waveform for a bridge driver. A one-hot select input picks one of three binary divisions of the reference: 128, 256 or 512 cycles per switching period. The same select also picks a duty tick that runs at exactly eight times the chosen switching rate. Duty is set by a 4-bit step value and comes in eighths of a period. At every period boundary a one-shot timer loads the step value. The PWM command then stays high for that many ticks and stays low for the rest of the period.

A square wave at one sixty-fourth of the reference, with 50% duty, is produced all the time for a charge pump. It does not depend on the select. A one-cycle strobe marks each period boundary for downstream logic. The block is held inactive while the active-low power-good/reset input is low. If the select is not exactly one-hot, the PWM command is held low, period strobes stop and an error flag is raised.

Top module: `stepped_pwm_gen`

## Requirements
- R1: While rst_n is low, pwm_out, period_start, pump_clk and sel_err are all 0.
- R2: pump_clk repeats every 64 clock cycles, high for 32 and low for 32. This holds for every value of sel, including invalid ones.
- R3: period_start pulses for exactly one cycle. Consecutive pulses are 128 cycles apart when sel=3'b001, 256 when sel=3'b010 and 512 when sel=3'b100.
- R4: In a period, pwm_out is high for step×(period/8) consecutive cycles, starting in the cycle where period_start is high, and low for the remaining cycles.
- R5: A step of 0 keeps pwm_out low for the whole period. A step of 8 keeps pwm_out high for the whole period.
- R6: Any step value from 9 to 15 gives the same result as step 8 (100% duty).
- R7: step is sampled only at a period boundary, which is the clock edge at which period_start rises. A change made while period_start is high, or later in the period, does not alter the current period. It takes effect in the next period.
- R8: When sel has zero bits set, or more than one, the following hold from the next cycle on: sel_err is 1, pwm_out is 0 and period_start never pulses. Once a one-hot sel returns, sel_err clears and normal periods resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz reference clock |
| rst_n | input | 1 | Active-low power-good / asynchronous reset |
| sel | input | 3 | One-hot rate select: bit0 divides by 128, bit1 by 256, bit2 by 512 |
| step | input | 4 | Duty step in eighths of a period; values above 8 clamp to 8 |
| period_start | output | 1 | One-cycle strobe at each switching period boundary |
| pwm_out | output | 1 | Raw PWM command |
| pump_clk | output | 1 | Charge-pump refresh clock, one sixty-fourth of clk, 50% duty |
| sel_err | output | 1 | High while sel is not one-hot |

## Verification
Two events can fall in the same cycle. Every period boundary is also a duty tick, so the reload and the decrement compete in that cycle. The step input may also change right at that boundary. The bench provokes both cases. It sets step to 8 and confirms that pwm_out never drops across a reload. It also changes step in the very cycle period_start is high. It then measures that period against the old step and the following period against the new step, counting high cycles between strobes.

// File: rtl/spwm_pkg.sv
`timescale 1ns/1ps
package spwm_pkg;

    // registered control flags of the top level
    typedef struct packed {
        logic period_start;
        logic sel_err;
    } ctl_state_t;

endpackage

// File: rtl/spwm_prescaler.sv
`timescale 1ns/1ps
module spwm_prescaler #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/spwm_rate_sel.sv
`timescale 1ns/1ps
module spwm_rate_sel #(
    parameter int unsigned RATES      = 3,
    parameter int unsigned BASE_SHIFT = 7,
    parameter int unsigned TICK_SHIFT = 3,
    parameter int unsigned CNT_W      = BASE_SHIFT + RATES - 1
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [RATES-1:0] sel_i,
    output logic             valid_o,
    output logic             period_o,
    output logic             tick_o
);

    logic [RATES-1:0] period_hit;
    logic [RATES-1:0] tick_hit;

    // one boundary detector and one tick detector per selectable rate
    for (genvar i = 0; i < RATES; i++) begin : g_rate
        localparam int unsigned PHI = BASE_SHIFT + i - 1;
        localparam int unsigned THI = BASE_SHIFT + i - TICK_SHIFT - 1;
        assign period_hit[i] = (cnt_i[PHI:0] == '0);
        assign tick_hit[i]   = (cnt_i[THI:0] == '0);
    end

    always_comb begin
        int unsigned ones;
        logic        p_any;
        logic        t_any;
        ones  = 0;
        p_any = 1'b0;
        t_any = 1'b0;
        for (int i = 0; i < RATES; i++) begin
            ones  = ones + 32'(sel_i[i]);
            p_any = p_any | (sel_i[i] & period_hit[i]);
            t_any = t_any | (sel_i[i] & tick_hit[i]);
        end
        valid_o  = (ones == 1);
        period_o = valid_o & p_any;
        tick_o   = valid_o & t_any;
    end

endmodule

// File: rtl/spwm_duty_timer.sv
`timescale 1ns/1ps
module spwm_duty_timer #(
    parameter int unsigned STEP_W     = 4,
    parameter int unsigned TICK_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              load_i,
    input  logic              tick_i,
    input  logic [STEP_W-1:0] step_i,
    output logic              pwm_o
);

    localparam int unsigned FULL  = 1 << TICK_SHIFT;
    localparam int unsigned REM_W = TICK_SHIFT + 1;

    typedef struct packed {
        logic [REM_W-1:0] rem;
        logic             pwm;
    } timer_t;

    timer_t st_d, st_q;
    logic [REM_W-1:0] clamped;

    always_comb begin
        if (32'(step_i) > FULL) clamped = REM_W'(FULL);
        else                    clamped = REM_W'(step_i);

        st_d = st_q;
        if (!valid_i) begin
            st_d.rem = '0;
            st_d.pwm = 1'b0;
        end else if (load_i) begin
            st_d.rem = clamped;
            st_d.pwm = (clamped != '0);
        end else if (tick_i) begin
            if (st_q.rem != '0) st_d.rem = st_q.rem - 1'b1;
            st_d.pwm = (st_q.rem > REM_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o = st_q.pwm;

    // R4
    low_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !pwm_o) |=> !pwm_o);

    // R6
    full_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && (32'(step_i) >= FULL)) |=> pwm_o);

    // R7
    no_reload_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (st_q.rem <= $past(st_q.rem)));

endmodule

// File: rtl/stepped_pwm_gen.sv
`timescale 1ns/1ps
module stepped_pwm_gen #(
    parameter int unsigned RATES      = 3,
    parameter int unsigned BASE_SHIFT = 7,
    parameter int unsigned TICK_SHIFT = 3,
    parameter int unsigned PUMP_SHIFT = 6,
    parameter int unsigned STEP_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RATES-1:0] sel,
    input  logic [STEP_W-1:0] step,
    output logic             period_start,
    output logic             pwm_out,
    output logic             pump_clk,
    output logic             sel_err
);
    import spwm_pkg::*;

    localparam int unsigned CNT_W = BASE_SHIFT + RATES - 1;

    logic [CNT_W-1:0] cnt;
    logic             valid;
    logic             period_hit;
    logic             tick_hit;
    ctl_state_t       ctl_d, ctl_q;

    spwm_prescaler #(.CNT_W(CNT_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_o (cnt)
    );

    spwm_rate_sel #(
        .RATES      (RATES),
        .BASE_SHIFT (BASE_SHIFT),
        .TICK_SHIFT (TICK_SHIFT),
        .CNT_W      (CNT_W)
    ) u_sel (
        .cnt_i    (cnt),
        .sel_i    (sel),
        .valid_o  (valid),
        .period_o (period_hit),
        .tick_o   (tick_hit)
    );

    spwm_duty_timer #(
        .STEP_W     (STEP_W),
        .TICK_SHIFT (TICK_SHIFT)
    ) u_duty (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid),
        .load_i  (period_hit),
        .tick_i  (tick_hit),
        .step_i  (step),
        .pwm_o   (pwm_out)
    );

    always_comb begin
        ctl_d              = ctl_q;
        ctl_d.period_start = period_hit;
        ctl_d.sel_err      = !valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign period_start = ctl_q.period_start;
    assign sel_err      = ctl_q.sel_err;
    assign pump_clk     = cnt[PUMP_SHIFT-1];

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> !period_start);

    // R2
    pump_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> !pump_clk);

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |-> (!pwm_out && !period_start));

endmodule

// File: tb/stepped_pwm_gen_test.sv
`timescale 1ns/1ps
module stepped_pwm_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    // {sel, step}
    localparam logic [6:0] VEC [NVEC] = '{
        {3'b001, 4'd0}, {3'b001, 4'd1}, {3'b001, 4'd3}, {3'b001, 4'd7},
        {3'b001, 4'd8}, {3'b001, 4'd12},
        {3'b010, 4'd2}, {3'b010, 4'd5}, {3'b010, 4'd8},
        {3'b100, 4'd4}, {3'b100, 4'd6}, {3'b100, 4'd15}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = 3'b001;
    logic [3:0] step = 4'd0;
    logic       period_start, pwm_out, pump_clk, sel_err;
    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stepped_pwm_gen uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .step(step),
        .period_start(period_start), .pwm_out(pwm_out),
        .pump_clk(pump_clk), .sel_err(sel_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_start();
        int n = 0;
        @(negedge clk);
        while (!period_start && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (!period_start) check("R3 strobe timeout", 0, 1);
    endtask

    task automatic measure(output int len, output int hi);
        len = 0;
        hi = 0;
        do begin
            len++;
            if (pwm_out) hi++;
            @(negedge clk);
        end while (!period_start && len < 5000);
    endtask

    task automatic pump_measure(output int hi, output int lo);
        int n = 0;
        hi = 0;
        lo = 0;
        while (pump_clk && n < 200) begin @(negedge clk); n++; end
        while (!pump_clk && n < 400) begin @(negedge clk); n++; end
        while (pump_clk && n < 600) begin hi++; @(negedge clk); n++; end
        while (!pump_clk && n < 800) begin lo++; @(negedge clk); n++; end
    endtask

    function automatic int period_of(input logic [2:0] s);
        case (s)
            3'b001:  return 128;
            3'b010:  return 256;
            default: return 512;
        endcase
    endfunction

    initial begin
        int len, hi, lo, seen_pwm, seen_ps, st, exp_hi;
        // R1 reset state
        repeat (5) @(negedge clk);
        check("R1 pwm_out in reset", int'(pwm_out), 0);
        check("R1 period_start in reset", int'(period_start), 0);
        check("R1 pump_clk in reset", int'(pump_clk), 0);
        check("R1 sel_err in reset", int'(sel_err), 0);
        rst_n = 1'b1;

        // table walk: R3 period, R4/R5/R6 duty
        for (int i = 0; i < NVEC; i++) begin
            sel  = VEC[i][6:4];
            step = VEC[i][3:0];
            wait_start();
            wait_start();
            measure(len, hi);
            st = (int'(step) > 8) ? 8 : int'(step);
            exp_hi = st * period_of(sel) / 8;
            check("R3 period length", len, period_of(sel));
            if (int'(step) > 8)                 check("R6 clamped duty", hi, exp_hi);
            else if (step == 0 || step == 8)    check("R5 edge duty", hi, exp_hi);
            else                                check("R4 duty cycles", hi, exp_hi);
        end

        // R5 step 8 across a reload boundary: never low over two periods
        sel = 3'b001;
        step = 4'd8;
        wait_start();
        wait_start();
        measure(len, hi);
        measure(lo, seen_pwm);
        check("R5 full duty two periods", hi + seen_pwm, len + lo);

        // R7 step change in the strobe cycle hits the next period only
        step = 4'd2;
        wait_start();
        wait_start();
        step = 4'd6;
        measure(len, hi);
        check("R7 old step kept", hi, 32);
        measure(len, hi);
        check("R7 new step applied", hi, 96);

        // R7 change in mid-period
        step = 4'd1;
        wait_start();
        wait_start();
        repeat (40) @(negedge clk);
        step = 4'd7;
        hi = 0;
        for (int k = 0; k < 88; k++) begin
            if (pwm_out) hi++;
            @(negedge clk);
        end
        check("R7 mid-period change ignored", hi, 0);

        // R2 pump with a valid select
        sel = 3'b100;
        pump_measure(hi, lo);
        check("R2 pump high", hi, 32);
        check("R2 pump low", lo, 32);

        // R8 invalid selects
        step = 4'd8;
        sel = 3'b000;
        repeat (3) @(negedge clk);
        check("R8 sel_err none set", int'(sel_err), 1);
        seen_pwm = 0;
        seen_ps = 0;
        for (int k = 0; k < 1100; k++) begin
            seen_pwm += int'(pwm_out);
            seen_ps  += int'(period_start);
            @(negedge clk);
        end
        check("R8 pwm low none set", seen_pwm, 0);
        check("R8 no strobe none set", seen_ps, 0);
        pump_measure(hi, lo);
        check("R2 pump high invalid sel", hi, 32);
        check("R2 pump low invalid sel", lo, 32);

        sel = 3'b011;
        repeat (3) @(negedge clk);
        check("R8 sel_err two set", int'(sel_err), 1);
        seen_pwm = 0;
        seen_ps = 0;
        for (int k = 0; k < 600; k++) begin
            seen_pwm += int'(pwm_out);
            seen_ps  += int'(period_start);
            @(negedge clk);
        end
        check("R8 pwm low two set", seen_pwm, 0);
        check("R8 no strobe two set", seen_ps, 0);

        sel = 3'b001;
        repeat (3) @(negedge clk);
        check("R8 sel_err cleared", int'(sel_err), 0);
        wait_start();
        wait_start();
        measure(len, hi);
        check("R8 recovered period", len, 128);
        check("R8 recovered duty", hi, 128);

        // R1 reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 pwm_out after reset", int'(pwm_out), 0);
        check("R1 period_start after reset", int'(period_start), 0);
        check("R1 pump_clk after reset", int'(pump_clk), 0);
        check("R1 sel_err after reset", int'(sel_err), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule